// File: doc/BRIEF.md
# Exception Entry Stacker

This block sequences the hardware side of exception entry for a small processor core. When a pending exception request is presented, it selects the stack that receives the interrupted context and aligns the frame to eight bytes. It then pushes eight context words to memory, one word at a time, through a write port with a valid/acknowledge handshake. A separate read port fetches the handler start address from the vector table during the same cycles as the pushes.

When every push and the vector read have been acknowledged, the block raises a one-cycle completion pulse. With that pulse it presents the handler address, the link-register return code, the new stack pointer and which stack pointer it belongs to, and the number of the exception that now becomes active. A request of strictly higher priority that arrives during entry takes over the vector fetch and becomes the serviced exception. The earlier request is not reported and so remains pending with the requester.

Top module: `exc_stacker`

## Requirements
- R1: On accepting a request, the frame goes on the main stack (`msp_in`) when `handler_mode` is 1 or `use_psp` is 0, otherwise on the process stack (`psp_in`). The lowest frame address is `(sp & ~7) - 32`. At completion `sp_out` equals that address and `sp_psp` is 1 only for the process stack.
- R2: Exactly eight word writes are made, in strictly descending address order, at lowest+28 down to lowest+0. They carry, in that order, status word, return PC, link register, R12, R3, R2, R1, R0. Each write holds its address and data until `wr_ack`.
- R3: When the selected stack pointer has bit 2 set, the word at `sp & ~7` is left unwritten and the stacked status word is `psr_in` with bit 9 set. Otherwise bit 9 of the stacked status word is cleared. All other status bits are copied unchanged.
- R4: The vector read goes to `vtor + 4*number`. It is requested from the first entry cycle, alongside the pushes, not after them, and is held until `rd_ack`.
- R5: `exc_ret` at completion is 0xFFFFFFF1 when entered from handler mode, 0xFFFFFFF9 from thread mode on the main stack, and 0xFFFFFFFD from thread mode on the process stack.
- R6: `enter_done` is a one-cycle pulse raised only after all eight write acknowledges and the vector read acknowledge. At that point `handler_pc` holds the fetched word and `active_num` the serviced exception number.
- R7: A request with a strictly smaller priority value that arrives before completion replaces the serviced exception, and the vector of the new number is fetched. This holds whether the first read is still outstanding or already done. `active_num` then reports only the new number.
- R8: A request with an equal or larger priority value during entry has no effect: the serviced number, the single vector read and the handler address stay those of the first request.
- R9: While and after reset, `wr_valid`, `rd_valid` and `enter_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Highest pending exception request present |
| req_prio | input | PW | Request priority, smaller value is more urgent |
| req_num | input | NW | Request exception number |
| handler_mode | input | 1 | Core currently in handler mode |
| use_psp | input | 1 | Thread mode uses the process stack |
| msp_in | input | AW | Main stack pointer |
| psp_in | input | AW | Process stack pointer |
| vtor | input | AW | Vector table base address |
| r0 | input | DW | Register R0 |
| r1 | input | DW | Register R1 |
| r2 | input | DW | Register R2 |
| r3 | input | DW | Register R3 |
| r12 | input | DW | Register R12 |
| lr_in | input | DW | Link register |
| ret_pc | input | DW | Return address of the interrupted program |
| psr_in | input | DW | Program status word |
| wr_valid | output | 1 | Stack write request |
| wr_addr | output | AW | Stack write address |
| wr_data | output | DW | Stack write data |
| wr_ack | input | 1 | Stack write accepted |
| rd_valid | output | 1 | Vector read request |
| rd_addr | output | AW | Vector read address |
| rd_data | input | DW | Vector read data |
| rd_ack | input | 1 | Vector read data valid |
| enter_done | output | 1 | Entry complete, handler may start |
| active_num | output | NW | Exception changing from pending to active |
| handler_pc | output | DW | Handler start address |
| exc_ret | output | DW | Return code for the link register |
| sp_out | output | AW | Stack pointer after stacking |
| sp_psp | output | 1 | `sp_out` belongs to the process stack |

## Verification
The assertions assume that the register values, mode bits, stack pointers and table base stay constant from acceptance to completion. They also assume that the memory returns `rd_data` in the same cycle as `rd_ack`. Under those assumptions a held write or read keeps its address and data stable. The bench sets every context input before it raises `req_valid` and changes only the request fields during entry. Its memory model answers with programmable gaps between acknowledges, so the overlap of the read with the pushes and the late-arrival windows can be steered.

// File: rtl/exc_stacker.sv
module exc_stacker #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int PW = 3,
  parameter int NW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [PW-1:0] req_prio,
  input  logic [NW-1:0] req_num,
  input  logic          handler_mode,
  input  logic          use_psp,
  input  logic [AW-1:0] msp_in,
  input  logic [AW-1:0] psp_in,
  input  logic [AW-1:0] vtor,
  input  logic [DW-1:0] r0,
  input  logic [DW-1:0] r1,
  input  logic [DW-1:0] r2,
  input  logic [DW-1:0] r3,
  input  logic [DW-1:0] r12,
  input  logic [DW-1:0] lr_in,
  input  logic [DW-1:0] ret_pc,
  input  logic [DW-1:0] psr_in,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  input  logic          wr_ack,
  output logic          rd_valid,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  input  logic          rd_ack,
  output logic          enter_done,
  output logic [NW-1:0] active_num,
  output logic [DW-1:0] handler_pc,
  output logic [DW-1:0] exc_ret,
  output logic [AW-1:0] sp_out,
  output logic          sp_psp
);

  localparam int FRAME_WORDS = 8;
  localparam int FRAME_BYTES = FRAME_WORDS * 4;
  localparam int CW = $clog2(FRAME_WORDS + 1);
  localparam int IW = $clog2(FRAME_WORDS);

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_DONE} st_t;

  st_t           st;
  logic [CW-1:0] wleft;
  logic [NW-1:0] cur_num, rd_num;
  logic [PW-1:0] cur_prio;
  logic          vec_ok, pad;

  logic          start, late, on_psp;
  logic [AW-1:0] sp_sel, low_n;
  logic [IW-1:0] widx;
  logic [NW-1:0] num_n;
  logic [DW-1:0] psr_st;

  assign start  = (st == S_IDLE) && req_valid;
  assign late   = (st == S_BUSY) && req_valid && (req_prio < cur_prio);
  assign num_n  = late ? req_num : cur_num;
  assign on_psp = !handler_mode && use_psp;
  assign sp_sel = on_psp ? psp_in : msp_in;
  assign low_n  = {sp_sel[AW-1:3], 3'b000} - AW'(FRAME_BYTES);

  assign wr_valid   = (st == S_BUSY) && (wleft != '0);
  assign widx       = IW'(wleft - CW'(1));
  assign wr_addr    = sp_out + AW'({widx, 2'b00});
  assign psr_st     = {psr_in[DW-1:10], pad, psr_in[8:0]};
  assign rd_valid   = (st == S_BUSY) && !vec_ok;
  assign rd_addr    = vtor + AW'({rd_num, 2'b00});
  assign enter_done = (st == S_DONE);
  assign active_num = cur_num;

  always_comb begin
    case (widx)
      3'd7:    wr_data = psr_st;
      3'd6:    wr_data = ret_pc;
      3'd5:    wr_data = lr_in;
      3'd4:    wr_data = r12;
      3'd3:    wr_data = r3;
      3'd2:    wr_data = r2;
      3'd1:    wr_data = r1;
      default: wr_data = r0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      wleft      <= '0;
      cur_num    <= '0;
      cur_prio   <= '0;
      rd_num     <= '0;
      vec_ok     <= 1'b0;
      pad        <= 1'b0;
      handler_pc <= '0;
      exc_ret    <= '0;
      sp_out     <= '0;
      sp_psp     <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st       <= S_BUSY;
          wleft    <= CW'(FRAME_WORDS);
          cur_num  <= req_num;
          cur_prio <= req_prio;
          rd_num   <= req_num;
          vec_ok   <= 1'b0;
          pad      <= sp_sel[2];
          sp_out   <= low_n;
          sp_psp   <= on_psp;
          exc_ret  <= handler_mode ? {{(DW-4){1'b1}}, 4'h1} :
                      use_psp      ? {{(DW-4){1'b1}}, 4'hD} :
                                     {{(DW-4){1'b1}}, 4'h9};
        end
        S_BUSY: begin
          if (late) begin
            cur_num  <= req_num;
            cur_prio <= req_prio;
          end
          if (wr_valid && wr_ack) wleft <= wleft - CW'(1);
          if (rd_valid && rd_ack) begin
            handler_pc <= rd_data;
            if (rd_num == num_n) vec_ok <= 1'b1;
            else                 rd_num <= num_n;
          end else if (vec_ok && late) begin
            vec_ok <= 1'b0;
            rd_num <= req_num;
          end
          if (wleft == '0 && vec_ok && !late) st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module exc_stacker_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_ack,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          rd_valid,
  input logic          rd_ack,
  input logic [AW-1:0] rd_addr,
  input logic          enter_done,
  input logic [DW-1:0] exc_ret,
  input logic [AW-1:0] sp_out
);

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ack |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R2
  AST_WR_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_addr[1:0] == 2'b00); // R2
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ack |=> rd_valid && $stable(rd_addr)); // R4
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    enter_done |-> !wr_valid && !rd_valid); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    enter_done |=> !enter_done); // R6
  AST_EXC_RET_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    enter_done |-> (exc_ret == {{(DW-4){1'b1}}, 4'h1} ||
                    exc_ret == {{(DW-4){1'b1}}, 4'h9} ||
                    exc_ret == {{(DW-4){1'b1}}, 4'hD})); // R5
  AST_SP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    enter_done |-> sp_out[2:0] == 3'b000); // R1
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |-> !wr_valid && !rd_valid && !enter_done); // R9

endmodule

bind exc_stacker exc_stacker_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ack(wr_ack),
  .wr_addr(wr_addr), .wr_data(wr_data), .rd_valid(rd_valid),
  .rd_ack(rd_ack), .rd_addr(rd_addr), .enter_done(enter_done),
  .exc_ret(exc_ret), .sp_out(sp_out)
);

// File: tb/sim_exc_stacker.sv
module sim_exc_stacker;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic        req_valid = 0, handler_mode = 0, use_psp = 0;
  logic [2:0]  req_prio = 0;
  logic [5:0]  req_num = 0;
  logic [31:0] msp_in = 0, psp_in = 0, vtor = 32'h200;
  logic [31:0] r0, r1, r2, r3, r12, lr_in, ret_pc, psr_in;
  logic        wr_valid, wr_ack, rd_valid, rd_ack, enter_done, sp_psp;
  logic [31:0] wr_addr, wr_data, rd_addr, rd_data, handler_pc, exc_ret, sp_out;
  logic [5:0]  active_num;

  exc_stacker u0 (.*);

  logic [31:0] mem [0:255];
  logic [31:0] wlog [0:15];
  logic [31:0] rlog [0:7];
  int rwn [0:7];
  int wn, rn, wdly, rdly, wgap, rgap;
  int vectors = 0, miscompares = 0;

  assign wr_ack  = wr_valid && wgap == 0;
  assign rd_ack  = rd_valid && rgap == 0;
  assign rd_data = mem[rd_addr[9:2]];

  always @(posedge clk) begin
    if (wr_valid && wr_ack) begin
      mem[wr_addr[9:2]] <= wr_data;
      if (wn < 16) wlog[wn] <= wr_addr;
      wn <= wn + 1; wgap <= wdly;
    end else if (wr_valid && wgap != 0) wgap <= wgap - 1;
    if (rd_valid && rd_ack) begin
      if (rn < 8) begin rlog[rn] <= rd_addr; rwn[rn] <= wn; end
      rn <= rn + 1; rgap <= rdly;
    end else if (rd_valid && rgap != 0) rgap <= rgap - 1;
  end

  function automatic logic [31:0] vec(input int n);
    return 32'h0800_0001 + n * 32'h100;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic setup(input logic [31:0] base, input logic [31:0] psr,
                       input int wd, input int rdl);
    r0 = base; r1 = base + 1; r2 = base + 2; r3 = base + 3;
    r12 = base + 12; lr_in = base + 14; ret_pc = base + 15; psr_in = psr;
    wdly = wd; rdly = rdl; wgap = wd; rgap = rdl; wn = 0; rn = 0;
  endtask

  task automatic request(input logic [2:0] p, input logic [5:0] n);
    req_prio = p; req_num = n; req_valid = 1;
  endtask

  int cyc;
  task automatic wait_done;
    cyc = 0;
    do begin
      @(negedge clk); cyc++;
      if (enter_done && (wn != 8 || rn == 0))
        chk("R6 early completion", 32'(wn), 32'd8);
    end while (!enter_done && cyc < 600);
    req_valid = 0;
    chk("R6 completion pulse", {31'd0, enter_done}, 32'd1);
    @(negedge clk);
    chk("R6 single pulse", {31'd0, enter_done}, 32'd0);
  endtask

  task automatic check_frame(input logic [31:0] sp, input logic [31:0] base);
    logic [31:0] low, ps;
    low = {sp[31:3], 3'b000} - 32;
    ps  = {psr_in[31:10], sp[2], psr_in[8:0]};
    chk("R1 sp_out", sp_out, low);
    chk("R2 write count", 32'(wn), 32'd8);
    for (int i = 0; i < 8; i++) chk("R2 write order", wlog[i], low + 28 - 4 * i);
    chk("R3 stacked psr", mem[(low + 28) >> 2], ps);
    chk("R2 pc word", mem[(low + 24) >> 2], base + 15);
    chk("R2 lr word", mem[(low + 20) >> 2], base + 14);
    chk("R2 r12 word", mem[(low + 16) >> 2], base + 12);
    for (int i = 0; i < 4; i++) chk("R2 r0-r3 word", mem[(low >> 2) + i], base + i);
  endtask

  task automatic t_reset;
    chk("R9 wr_valid", {31'd0, wr_valid}, 0);
    chk("R9 rd_valid", {31'd0, rd_valid}, 0);
    chk("R9 enter_done", {31'd0, enter_done}, 0);
  endtask

  task automatic t_basic;
    handler_mode = 0; use_psp = 0; msp_in = 32'h180; psp_in = 32'h1C4;
    setup(32'hA000_0000, 32'h6100_0203, 0, 0);
    request(3, 5); wait_done;
    check_frame(32'h180, 32'hA000_0000);
    chk("R1 sp_psp", {31'd0, sp_psp}, 0);
    chk("R5 thread msp", exc_ret, 32'hFFFF_FFF9);
    chk("R6 handler_pc", handler_pc, vec(5));
    chk("R6 active_num", {26'd0, active_num}, 5);
    chk("R4 vector addr", rlog[0], 32'h200 + 20);
    chk("R4 read count", 32'(rn), 1);
  endtask

  task automatic t_pad;
    handler_mode = 0; use_psp = 1; msp_in = 32'h100; psp_in = 32'h1C4;
    mem[32'h1C0 >> 2] = 32'hDEAD_BEEF;
    setup(32'hB000_0000, 32'h2100_0001, 1, 2);
    request(2, 7); wait_done;
    check_frame(32'h1C4, 32'hB000_0000);
    chk("R3 pad word untouched", mem[32'h1C0 >> 2], 32'hDEAD_BEEF);
    chk("R1 sp_psp", {31'd0, sp_psp}, 1);
    chk("R5 thread psp", exc_ret, 32'hFFFF_FFFD);
    chk("R6 handler_pc", handler_pc, vec(7));
  endtask

  task automatic t_handler;
    handler_mode = 1; use_psp = 1; msp_in = 32'h0F8; psp_in = 32'h1C4;
    setup(32'hC000_0000, 32'h0000_0210, 0, 1);
    request(1, 33); wait_done;
    check_frame(32'h0F8, 32'hC000_0000);
    chk("R1 handler on msp", {31'd0, sp_psp}, 0);
    chk("R5 handler mode", exc_ret, 32'hFFFF_FFF1);
    chk("R6 active_num", {26'd0, active_num}, 33);
  endtask

  task automatic t_overlap;
    handler_mode = 0; use_psp = 0; msp_in = 32'h190;
    setup(32'hD000_0000, 32'h0, 3, 0);
    request(3, 12); wait_done;
    chk("R4 read done before pushes end", {31'd0, rwn[0] < 8}, 1);
    chk("R6 handler_pc", handler_pc, vec(12));
  endtask

  task automatic t_slowread;
    handler_mode = 0; use_psp = 0; msp_in = 32'h190;
    setup(32'hE000_0000, 32'h0, 0, 25);
    request(3, 13); wait_done;
    chk("R6 waits for read", {31'd0, cyc >= 25}, 1);
    chk("R6 handler_pc", handler_pc, vec(13));
  endtask

  task automatic t_late(input int rdl, input int wd, input int after);
    handler_mode = 0; use_psp = 0; msp_in = 32'h180;
    setup(32'hF000_0000, 32'h0, wd, rdl);
    request(4, 10);
    while (wn < after) @(negedge clk);
    request(1, 20); wait_done;
    check_frame(32'h180, 32'hF000_0000);
    chk("R7 active_num", {26'd0, active_num}, 20);
    chk("R7 handler_pc", handler_pc, vec(20));
    chk("R7 refetch count", 32'(rn), 2);
    chk("R7 refetch addr", rlog[1], 32'h200 + 80);
  endtask

  task automatic t_ignore;
    handler_mode = 0; use_psp = 0; msp_in = 32'h180;
    setup(32'h1000_0000, 32'h0, 2, 0);
    request(4, 10);
    while (wn < 2) @(negedge clk);
    request(4, 30);
    while (wn < 4) @(negedge clk);
    request(6, 31); wait_done;
    chk("R8 active_num", {26'd0, active_num}, 10);
    chk("R8 read count", 32'(rn), 1);
    chk("R8 handler_pc", handler_pc, vec(10));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    for (int i = 0; i < 64; i++) mem[128 + i] = vec(i);
    wn = 0; rn = 0; wdly = 0; rdly = 0; wgap = 0; rgap = 0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_pad;
    t_handler;
    t_overlap;
    t_slowread;
    t_late(0, 2, 3);
    t_late(12, 0, 2);
    t_ignore;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(8 * 150000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule